// File: doc/BRIEF.md
# Block-Aware Multi-Level Translation Cache

This block is a fully associative translation cache for an I/O memory management unit. Each entry describes a whole mapping, either a single page or a large block, so a block mapping costs one entry no matter how many pages inside it are used. An entry records its context identifier, the base input address of the mapping, the mapping mask (size minus one), the output base, the access permissions, the translation level (0 to 3) and a granule code (1 = 4 KB, 2 = 16 KB, 3 = 64 KB).

A lookup carries a context identifier, an input address, a granule code and an input-size field `tsz`. The probe FSM first works out the start level as `4 - (inputsize - 4) / stride`, where `inputsize = 64 - tsz` and `stride = log2(granule) - 3`. It then probes one level per clock, from the start level towards level 3. At level L the mapping size is `2^(log2(granule) + (3 - L) * stride)`. The first level with a matching entry ends the probe with a hit. A miss is reported after level 3.

The fill port stores a walk result. It picks the lowest free slot, or, when every slot is taken, clears the whole cache and writes slot 0. The maintenance port removes entries in one cycle, in one of three ways:
- every entry;
- every entry of one context;
- every entry whose mapping covers a given address, for one context or for any context.

The FSM has three states:
- IDLE: leaves for PROBE when a request arrives.
- PROBE: stays in PROBE while a maintenance operation is applied or while it moves down one level. It goes to RESP on a hit or on a miss at level 3.
- RESP: raises the done strobe and returns to IDLE.

Top module: `iotlb_cache`

## Requirements
- R1: After reset no entry is valid, `lk_done` is low and the FSM is in IDLE, so any lookup misses.
- R2: A request accepted in IDLE is probed starting at the start level derived from `lk_tg` and `lk_tsz`, one level per clock. `lk_done` rises after (hit level − start level + 1) clock edges following the request edge, or after (4 − start level) edges on a miss.
- R3: An entry hits only when the context identifier, the granule code and the level are all equal, and the entry base equals the request address with that level's mask bits cleared.
- R4: On a hit `lk_paddr` = entry output base + (`lk_addr` AND entry mask). `lk_mask` returns the entry mask and `lk_perm` the entry permissions (bit 0 read, bit 1 write).
- R5: A write request (`lk_write` = 1) that hits an entry whose permission bit 1 is clear returns `lk_hit` = 1, `lk_fault` = 1 and `lk_paddr` = 0.
- R6: A fill stores the input and output bases with the mask bits of its level and granule cleared, in the lowest free slot. A fill into a full cache first invalidates every entry and then stores the new one.
- R7: Maintenance code 0 (all) clears every entry in one cycle.
- R8: Maintenance code 1 (by context) clears, in one cycle, every entry whose context identifier equals `mt_asid`. Other contexts are kept.
- R9: Maintenance code 2 (by address) clears every entry whose base equals `mt_addr` AND NOT entry mask. It requires a matching context unless `mt_any_asid` is 1.
- R10: A maintenance operation during PROBE holds the probe at its current level for that cycle. The probe then continues against the updated contents.
- R11: `lk_done` is a single-cycle strobe. A miss returns `lk_hit`, `lk_fault`, `lk_paddr` and `lk_mask` all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lk_req | input | 1 | Lookup request, accepted in IDLE |
| lk_write | input | 1 | Request is a write |
| lk_asid | input | ASW | Lookup context identifier |
| lk_addr | input | AW | Lookup input address |
| lk_tg | input | 2 | Lookup granule code (1..3) |
| lk_tsz | input | 6 | Lookup input-size field |
| lk_done | output | 1 | Result strobe |
| lk_hit | output | 1 | Entry found |
| lk_fault | output | 1 | Write to a read-only mapping |
| lk_paddr | output | AW | Translated address |
| lk_mask | output | AW | Mapping mask of the hit entry |
| lk_perm | output | 2 | Permissions of the hit entry |
| fl_valid | input | 1 | Fill strobe |
| fl_asid | input | ASW | Fill context identifier |
| fl_iova | input | AW | Fill input address |
| fl_tg | input | 2 | Fill granule code |
| fl_lvl | input | 2 | Fill translation level |
| fl_obase | input | AW | Fill output address |
| fl_perm | input | 2 | Fill permissions |
| mt_valid | input | 1 | Maintenance strobe |
| mt_op | input | 2 | Maintenance operation: 0 all, 1 by context, 2 by address |
| mt_any_asid | input | 1 | Context wildcard for operation 2 |
| mt_asid | input | ASW | Maintenance context identifier |
| mt_addr | input | AW | Maintenance address |

## Verification
The bench builds the cache with `N_ENTRIES` = 4, keeping AW = 48 and ASW = 16. With only four slots the full-cache flush on the fifth fill can be reached in a few cycles. The 48-bit address still holds 4 KB level-0 and 64 KB level-1 start points, so probes run across three or four levels. 1 GB, 2 MB, 4 KB and 64 KB mappings sit side by side. Two `tsz` values are used so that the start-level formula, and with it the done latency, can be observed directly.

// File: rtl/iotlb_pkg.sv
package iotlb_pkg;

    typedef enum logic [1:0] {
        MT_ALL  = 2'd0,
        MT_ASID = 2'd1,
        MT_ADDR = 2'd2
    } mt_op_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_PROBE = 2'd1,
        S_RESP  = 2'd2
    } pstate_e;

    // log2 of the granule: 12, 14 or 16 for codes 1, 2, 3
    function automatic logic [6:0] gran_log2(input logic [1:0] tg);
        return 7'd10 + {4'd0, tg, 1'b0};
    endfunction

    // log2 of the mapping size covered by one entry at a level
    function automatic logic [6:0] lvl_shift(input logic [1:0] tg, input logic [1:0] lvl);
        logic [6:0] g;
        logic [6:0] up;
        g  = gran_log2(tg);
        up = {5'd0, 2'd3 - lvl};
        return g + up * (g - 7'd3);
    endfunction

    function automatic logic [63:0] lvl_mask(input logic [1:0] tg, input logic [1:0] lvl);
        return (64'd1 << lvl_shift(tg, lvl)) - 64'd1;
    endfunction

    // first level to probe, from granule code and input-size field
    function automatic logic [1:0] start_lvl(input logic [1:0] tg, input logic [5:0] tsz);
        logic [6:0] isz;
        logic [6:0] q;
        isz = 7'd64 - {1'b0, tsz};
        case (tg)
            2'd2:    q = (isz - 7'd4) / 7'd11;
            2'd3:    q = (isz - 7'd4) / 7'd13;
            default: q = (isz - 7'd4) / 7'd9;
        endcase
        if (q >= 7'd4)      return 2'd0;
        else if (q == 7'd0) return 2'd3;
        else                return 2'(3'd4 - q[2:0]);
    endfunction

endpackage

// File: rtl/iotlb_entry_array.sv
module iotlb_entry_array
    import iotlb_pkg::*;
#(
    parameter int N_ENTRIES = 256,
    parameter int AW        = 48,
    parameter int ASW       = 16,
    localparam int IW       = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           fl_valid,
    input  logic [ASW-1:0] fl_asid,
    input  logic [AW-1:0]  fl_iova,
    input  logic [1:0]     fl_tg,
    input  logic [1:0]     fl_lvl,
    input  logic [AW-1:0]  fl_obase,
    input  logic [1:0]     fl_perm,
    input  logic           mt_valid,
    input  logic [1:0]     mt_op,
    input  logic           mt_any_asid,
    input  logic [ASW-1:0] mt_asid,
    input  logic [AW-1:0]  mt_addr,
    input  logic [ASW-1:0] pr_asid,
    input  logic [AW-1:0]  pr_addr,
    input  logic [1:0]     pr_tg,
    input  logic [1:0]     pr_lvl,
    output logic           pr_hit,
    output logic [AW-1:0]  pr_obase,
    output logic [AW-1:0]  pr_mask,
    output logic [1:0]     pr_perm
);

    logic [N_ENTRIES-1:0] vld_q, vld_d, kill, phit;
    logic [ASW-1:0] asid_q  [N_ENTRIES];
    logic [AW-1:0]  base_q  [N_ENTRIES];
    logic [AW-1:0]  mask_q  [N_ENTRIES];
    logic [AW-1:0]  obase_q [N_ENTRIES];
    logic [1:0]     tg_q    [N_ENTRIES];
    logic [1:0]     lvl_q   [N_ENTRIES];
    logic [1:0]     perm_q  [N_ENTRIES];

    logic [AW-1:0] pmask, fmask, pkey;
    logic [IW-1:0] free_idx, slot;
    logic          free_ok;

    assign pmask = AW'(lvl_mask(pr_tg, pr_lvl));
    assign fmask = AW'(lvl_mask(fl_tg, fl_lvl));
    assign pkey  = pr_addr & ~pmask;

    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_ent
        logic mt_asid_eq;
        assign mt_asid_eq = (asid_q[g] == mt_asid);
        assign phit[g] = vld_q[g] && (asid_q[g] == pr_asid) && (tg_q[g] == pr_tg)
                      && (lvl_q[g] == pr_lvl) && (base_q[g] == pkey);
        assign kill[g] = mt_valid && (
                   (mt_op == MT_ALL)
                || ((mt_op == MT_ASID) && mt_asid_eq)
                || ((mt_op == MT_ADDR) && (mt_any_asid || mt_asid_eq)
                    && (base_q[g] == (mt_addr & ~mask_q[g]))));
    end

    // lowest free slot
    always_comb begin
        free_ok  = 1'b0;
        free_idx = '0;
        for (int i = N_ENTRIES - 1; i >= 0; i--) begin
            if (!vld_q[i]) begin
                free_ok  = 1'b1;
                free_idx = IW'(i);
            end
        end
    end

    assign slot = free_ok ? free_idx : '0;

    always_comb begin
        vld_d = vld_q & ~kill;
        if (fl_valid) begin
            if (!free_ok) vld_d = '0;
            vld_d[slot] = 1'b1;
        end
    end

    // first hitting entry
    always_comb begin
        pr_hit   = |phit;
        pr_obase = '0;
        pr_mask  = '0;
        pr_perm  = '0;
        for (int i = N_ENTRIES - 1; i >= 0; i--) begin
            if (phit[i]) begin
                pr_obase = obase_q[i];
                pr_mask  = mask_q[i];
                pr_perm  = perm_q[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vld_q <= '0;
        else        vld_q <= vld_d;
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < N_ENTRIES; i++) begin
            if (fl_valid && (IW'(i) == slot)) begin
                asid_q[i]  <= fl_asid;
                base_q[i]  <= fl_iova & ~fmask;
                mask_q[i]  <= fmask;
                obase_q[i] <= fl_obase & ~fmask;
                tg_q[i]    <= fl_tg;
                lvl_q[i]   <= fl_lvl;
                perm_q[i]  <= fl_perm;
            end
        end
    end

endmodule

// File: rtl/iotlb_probe_fsm.sv
module iotlb_probe_fsm
    import iotlb_pkg::*;
#(
    parameter int AW  = 48,
    parameter int ASW = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           lk_req,
    input  logic           lk_write,
    input  logic [ASW-1:0] lk_asid,
    input  logic [AW-1:0]  lk_addr,
    input  logic [1:0]     lk_tg,
    input  logic [5:0]     lk_tsz,
    input  logic           hold,
    input  logic           pr_hit,
    input  logic [AW-1:0]  pr_obase,
    input  logic [AW-1:0]  pr_mask,
    input  logic [1:0]     pr_perm,
    output logic [ASW-1:0] pr_asid,
    output logic [AW-1:0]  pr_addr,
    output logic [1:0]     pr_tg,
    output logic [1:0]     pr_lvl,
    output logic           lk_done,
    output logic           lk_hit,
    output logic           lk_fault,
    output logic [AW-1:0]  lk_paddr,
    output logic [AW-1:0]  lk_mask,
    output logic [1:0]     lk_perm
);

    pstate_e        state_q, state_d;
    logic [1:0]     lvl_q, tg_q, perm_q;
    logic [ASW-1:0] asid_q;
    logic [AW-1:0]  addr_q, pa_q, mask_q;
    logic           wr_q, hit_q, fault_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (lk_req) state_d = S_PROBE;
            S_PROBE: if (!hold && (pr_hit || lvl_q == 2'd3)) state_d = S_RESP;
            S_RESP:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // request and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q   <= '0;
            tg_q    <= '0;
            asid_q  <= '0;
            addr_q  <= '0;
            wr_q    <= 1'b0;
            hit_q   <= 1'b0;
            fault_q <= 1'b0;
            pa_q    <= '0;
            mask_q  <= '0;
            perm_q  <= '0;
        end else if (state_q == S_IDLE && lk_req) begin
            lvl_q  <= start_lvl(lk_tg, lk_tsz);
            tg_q   <= lk_tg;
            asid_q <= lk_asid;
            addr_q <= lk_addr;
            wr_q   <= lk_write;
        end else if (state_q == S_PROBE && !hold) begin
            if (pr_hit) begin
                hit_q   <= 1'b1;
                mask_q  <= pr_mask;
                perm_q  <= pr_perm;
                if (wr_q && !pr_perm[1]) begin
                    fault_q <= 1'b1;
                    pa_q    <= '0;
                end else begin
                    fault_q <= 1'b0;
                    pa_q    <= pr_obase + (addr_q & pr_mask);
                end
            end else if (lvl_q == 2'd3) begin
                hit_q   <= 1'b0;
                fault_q <= 1'b0;
                pa_q    <= '0;
                mask_q  <= '0;
                perm_q  <= '0;
            end else begin
                lvl_q <= lvl_q + 2'd1;
            end
        end
    end

    // outputs
    always_comb begin
        lk_done  = (state_q == S_RESP);
        lk_hit   = lk_done & hit_q;
        lk_fault = lk_done & fault_q;
        lk_paddr = lk_done ? pa_q : '0;
        lk_mask  = lk_done ? mask_q : '0;
        lk_perm  = lk_done ? perm_q : '0;
        pr_asid  = asid_q;
        pr_addr  = addr_q;
        pr_tg    = tg_q;
        pr_lvl   = lvl_q;
    end

endmodule

// File: rtl/iotlb_cache.sv
module iotlb_cache #(
    parameter int N_ENTRIES = 256,
    parameter int AW        = 48,
    parameter int ASW       = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           lk_req,
    input  logic           lk_write,
    input  logic [ASW-1:0] lk_asid,
    input  logic [AW-1:0]  lk_addr,
    input  logic [1:0]     lk_tg,
    input  logic [5:0]     lk_tsz,
    output logic           lk_done,
    output logic           lk_hit,
    output logic           lk_fault,
    output logic [AW-1:0]  lk_paddr,
    output logic [AW-1:0]  lk_mask,
    output logic [1:0]     lk_perm,
    input  logic           fl_valid,
    input  logic [ASW-1:0] fl_asid,
    input  logic [AW-1:0]  fl_iova,
    input  logic [1:0]     fl_tg,
    input  logic [1:0]     fl_lvl,
    input  logic [AW-1:0]  fl_obase,
    input  logic [1:0]     fl_perm,
    input  logic           mt_valid,
    input  logic [1:0]     mt_op,
    input  logic           mt_any_asid,
    input  logic [ASW-1:0] mt_asid,
    input  logic [AW-1:0]  mt_addr
);

    logic [ASW-1:0] pr_asid;
    logic [AW-1:0]  pr_addr, pr_obase, pr_mask;
    logic [1:0]     pr_tg, pr_lvl, pr_perm;
    logic           pr_hit;

    iotlb_probe_fsm #(.AW(AW), .ASW(ASW)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_req   (lk_req),
        .lk_write (lk_write),
        .lk_asid  (lk_asid),
        .lk_addr  (lk_addr),
        .lk_tg    (lk_tg),
        .lk_tsz   (lk_tsz),
        .hold     (mt_valid),
        .pr_hit   (pr_hit),
        .pr_obase (pr_obase),
        .pr_mask  (pr_mask),
        .pr_perm  (pr_perm),
        .pr_asid  (pr_asid),
        .pr_addr  (pr_addr),
        .pr_tg    (pr_tg),
        .pr_lvl   (pr_lvl),
        .lk_done  (lk_done),
        .lk_hit   (lk_hit),
        .lk_fault (lk_fault),
        .lk_paddr (lk_paddr),
        .lk_mask  (lk_mask),
        .lk_perm  (lk_perm)
    );

    iotlb_entry_array #(.N_ENTRIES(N_ENTRIES), .AW(AW), .ASW(ASW)) u_arr (
        .clk         (clk),
        .rst_n       (rst_n),
        .fl_valid    (fl_valid),
        .fl_asid     (fl_asid),
        .fl_iova     (fl_iova),
        .fl_tg       (fl_tg),
        .fl_lvl      (fl_lvl),
        .fl_obase    (fl_obase),
        .fl_perm     (fl_perm),
        .mt_valid    (mt_valid),
        .mt_op       (mt_op),
        .mt_any_asid (mt_any_asid),
        .mt_asid     (mt_asid),
        .mt_addr     (mt_addr),
        .pr_asid     (pr_asid),
        .pr_addr     (pr_addr),
        .pr_tg       (pr_tg),
        .pr_lvl      (pr_lvl),
        .pr_hit      (pr_hit),
        .pr_obase    (pr_obase),
        .pr_mask     (pr_mask),
        .pr_perm     (pr_perm)
    );

endmodule

// File: rtl/iotlb_cache_chk.sv
module iotlb_cache_chk #(
    parameter int AW = 48
) (
    input logic          clk,
    input logic          rst_n,
    input logic          lk_req,
    input logic          lk_done,
    input logic          lk_hit,
    input logic          lk_fault,
    input logic [AW-1:0] lk_paddr,
    input logic [AW-1:0] lk_mask,
    input logic          fl_valid,
    input logic          mt_valid,
    input logic [1:0]    mt_op,
    input logic          pr_hit,
    input logic [1:0]    pr_lvl,
    input logic [AW-1:0] pr_addr
);

    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        lk_done |=> !lk_done);

    p_miss_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_done && !lk_hit) |-> (lk_fault == 1'b0 && lk_paddr == '0 && lk_mask == '0));

    p_fault_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_done && lk_fault) |-> (lk_hit && lk_paddr == '0));

    p_offset_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_done && lk_hit && !lk_fault) |-> ((lk_paddr & lk_mask) == (pr_addr & lk_mask)));

    p_flush_no_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mt_valid && mt_op == 2'd0 && !fl_valid) |=> !pr_hit);

    p_hold_level_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mt_valid && !lk_req) |=> $stable(pr_lvl));

endmodule

bind iotlb_cache iotlb_cache_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_req   (lk_req),
    .lk_done  (lk_done),
    .lk_hit   (lk_hit),
    .lk_fault (lk_fault),
    .lk_paddr (lk_paddr),
    .lk_mask  (lk_mask),
    .fl_valid (fl_valid),
    .mt_valid (mt_valid),
    .mt_op    (mt_op),
    .pr_hit   (pr_hit),
    .pr_lvl   (pr_lvl),
    .pr_addr  (pr_addr)
);

// File: tb/sim_iotlb_cache.sv
`timescale 1ns/1ps
module sim_iotlb_cache;

    localparam int N  = 4;
    localparam int AW = 48;
    localparam int AS = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lk_req = 0, lk_write = 0;
    logic [AS-1:0] lk_asid = '0;
    logic [AW-1:0] lk_addr = '0;
    logic [1:0]    lk_tg = 2'd1;
    logic [5:0]    lk_tsz = 6'd16;
    logic          lk_done, lk_hit, lk_fault;
    logic [AW-1:0] lk_paddr, lk_mask;
    logic [1:0]    lk_perm;
    logic          fl_valid = 0;
    logic [AS-1:0] fl_asid = '0;
    logic [AW-1:0] fl_iova = '0, fl_obase = '0;
    logic [1:0]    fl_tg = 2'd1, fl_lvl = 2'd3, fl_perm = 2'd3;
    logic          mt_valid = 0, mt_any_asid = 0;
    logic [1:0]    mt_op = 2'd0;
    logic [AS-1:0] mt_asid = '0;
    logic [AW-1:0] mt_addr = '0;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    iotlb_cache #(.N_ENTRIES(N), .AW(AW), .ASW(AS)) u0 (
        .clk(clk), .rst_n(rst_n),
        .lk_req(lk_req), .lk_write(lk_write), .lk_asid(lk_asid), .lk_addr(lk_addr),
        .lk_tg(lk_tg), .lk_tsz(lk_tsz), .lk_done(lk_done), .lk_hit(lk_hit),
        .lk_fault(lk_fault), .lk_paddr(lk_paddr), .lk_mask(lk_mask), .lk_perm(lk_perm),
        .fl_valid(fl_valid), .fl_asid(fl_asid), .fl_iova(fl_iova), .fl_tg(fl_tg),
        .fl_lvl(fl_lvl), .fl_obase(fl_obase), .fl_perm(fl_perm),
        .mt_valid(mt_valid), .mt_op(mt_op), .mt_any_asid(mt_any_asid),
        .mt_asid(mt_asid), .mt_addr(mt_addr)
    );

    typedef struct packed {
        logic [15:0] asid;
        logic [47:0] addr;
        logic [1:0]  tg;
        logic [5:0]  tsz;
        logic        wr;
        logic        hit;
        logic        fault;
        logic [47:0] pa;
        logic [3:0]  n;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{16'd5, 48'h0000_4023_4567, 2'd1, 6'd16, 1'b0, 1'b1, 1'b0, 48'h0000_8003_4567, 4'd3},
        '{16'd5, 48'h0000_0001_3ABC, 2'd1, 6'd16, 1'b0, 1'b1, 1'b0, 48'h0000_0077_7ABC, 4'd4},
        '{16'd5, 48'h0000_0001_3ABC, 2'd1, 6'd16, 1'b1, 1'b1, 1'b1, 48'h0,              4'd4},
        '{16'd7, 48'h0000_C123_4568, 2'd1, 6'd16, 1'b1, 1'b1, 1'b0, 48'h0001_0123_4568, 4'd2},
        '{16'd5, 48'h0000_C000_0000, 2'd1, 6'd16, 1'b0, 1'b0, 1'b0, 48'h0,              4'd4},
        '{16'd5, 48'h0000_0005_1234, 2'd3, 6'd16, 1'b0, 1'b1, 1'b0, 48'h0000_0009_1234, 4'd3},
        '{16'd5, 48'h0000_0005_1234, 2'd1, 6'd16, 1'b0, 1'b0, 1'b0, 48'h0,              4'd4},
        '{16'd5, 48'h0000_4020_0000, 2'd1, 6'd25, 1'b0, 1'b1, 1'b0, 48'h0000_8000_0000, 4'd2}
    };

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic lookup(input logic [15:0] asid, input logic [47:0] addr, input logic [1:0] tg,
                          input logic [5:0] tsz, input logic wr,
                          output logic hit, output logic fault, output logic [47:0] pa,
                          output logic [47:0] msk, output logic [1:0] perm, output int n);
        @(negedge clk);
        lk_req = 1; lk_asid = asid; lk_addr = addr; lk_tg = tg; lk_tsz = tsz; lk_write = wr;
        @(posedge clk);
        @(negedge clk);
        lk_req = 0;
        n = 0;
        while (!lk_done && n < 20) begin
            @(posedge clk); @(negedge clk);
            n++;
        end
        hit = lk_hit; fault = lk_fault; pa = lk_paddr; msk = lk_mask; perm = lk_perm;
    endtask

    task automatic fill(input logic [15:0] asid, input logic [47:0] iova, input logic [1:0] tg,
                        input logic [1:0] lvl, input logic [47:0] obase, input logic [1:0] perm);
        @(negedge clk);
        fl_valid = 1; fl_asid = asid; fl_iova = iova; fl_tg = tg; fl_lvl = lvl;
        fl_obase = obase; fl_perm = perm;
        @(negedge clk);
        fl_valid = 0;
    endtask

    task automatic maint(input logic [1:0] op, input logic any, input logic [15:0] asid,
                         input logic [47:0] addr);
        @(negedge clk);
        mt_valid = 1; mt_op = op; mt_any_asid = any; mt_asid = asid; mt_addr = addr;
        @(negedge clk);
        mt_valid = 0;
    endtask

    task automatic base_fills();
        fill(16'd5, 48'h0000_4020_0000, 2'd1, 2'd2, 48'h0000_8000_0000, 2'd3);
        fill(16'd5, 48'h0000_0001_3000, 2'd1, 2'd3, 48'h0000_0077_7000, 2'd1);
        fill(16'd7, 48'h0000_C000_0000, 2'd1, 2'd1, 48'h0001_0000_0000, 2'd3);
        fill(16'd5, 48'h0000_0005_0000, 2'd3, 2'd3, 48'h0000_0009_0000, 2'd3);
    endtask

    initial begin
        #(200000 * 8);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic h, f;
        logic [47:0] pa, msk;
        logic [1:0] pm;
        int n;

        repeat (3) @(negedge clk);
        chk(lk_done == 1'b0, "R1 done low in reset", 64'(lk_done), 64'd0);
        rst_n = 1;
        lookup(16'd5, 48'h0000_4023_4567, 2'd1, 6'd16, 1'b0, h, f, pa, msk, pm, n);
        chk(h == 1'b0, "R1 empty after reset", 64'(h), 64'd0);
        chk(n == 4, "R2 miss latency from level 0", 64'(n), 64'd4);

        base_fills();

        // table of lookups
        for (int i = 0; i < 8; i++) begin
            lookup(VEC[i].asid, VEC[i].addr, VEC[i].tg, VEC[i].tsz, VEC[i].wr, h, f, pa, msk, pm, n);
            chk(h == VEC[i].hit, $sformatf("R3 hit vec%0d", i), 64'(h), 64'(VEC[i].hit));
            chk(f == VEC[i].fault, $sformatf("R5 fault vec%0d", i), 64'(f), 64'(VEC[i].fault));
            chk(pa == VEC[i].pa, $sformatf("R4 paddr vec%0d", i), 64'(pa), 64'(VEC[i].pa));
            chk(n == int'(VEC[i].n), $sformatf("R2 latency vec%0d", i), 64'(n), 64'(VEC[i].n));
        end

        // mask and permissions returned
        lookup(16'd5, 48'h0000_4023_4567, 2'd1, 6'd16, 1'b0, h, f, pa, msk, pm, n);
        chk(msk == 48'h1F_FFFF, "R4 block mask", 64'(msk), 64'h1F_FFFF);
        chk(pm == 2'd3, "R4 perm rw", 64'(pm), 64'd3);
        @(negedge clk);
        chk(lk_done == 1'b0, "R11 done single cycle", 64'(lk_done), 64'd0);
        lookup(16'd5, 48'h0000_0001_3ABC, 2'd1, 6'd16, 1'b0, h, f, pa, msk, pm, n);
        chk(pm == 2'd1, "R4 perm read only", 64'(pm), 64'd1);

        // invalidate by address, context 5
        maint(2'd2, 1'b0, 16'd5, 48'h0000_4030_0000);
        lookup(16'd5, 48'h0000_4023_4567, 2'd1, 6'd16, 1'b0, h, f, pa, msk, pm, n);
        chk(h == 1'b0, "R9 covering block removed", 64'(h), 64'd0);
        chk(pa == 48'h0 && msk == 48'h0, "R11 miss outputs zero", 64'(pa | msk), 64'd0);
        lookup(16'd5, 48'h0000_0001_3ABC, 2'd1, 6'd16, 1'b0, h, f, pa, msk, pm, n);
        chk(h == 1'b1, "R9 other page kept", 64'(h), 64'd1);

        // wrong context, then wildcard
        maint(2'd2, 1'b0, 16'd9, 48'h0000_C000_0010);
        lookup(16'd7, 48'h0000_C123_4568, 2'd1, 6'd16, 1'b0, h, f, pa, msk, pm, n);
        chk(h == 1'b1, "R9 context mismatch keeps entry", 64'(h), 64'd1);
        maint(2'd2, 1'b1, 16'd9, 48'h0000_C000_0010);
        lookup(16'd7, 48'h0000_C123_4568, 2'd1, 6'd16, 1'b0, h, f, pa, msk, pm, n);
        chk(h == 1'b0, "R9 wildcard removes entry", 64'(h), 64'd0);

        // invalidate by context
        fill(16'd7, 48'h0000_C000_0000, 2'd1, 2'd1, 48'h0001_0000_0000, 2'd3);
        maint(2'd1, 1'b0, 16'd5, 48'h0);
        lookup(16'd5, 48'h0000_0001_3ABC, 2'd1, 6'd16, 1'b0, h, f, pa, msk, pm, n);
        chk(h == 1'b0, "R8 ctx 5 page removed", 64'(h), 64'd0);
        lookup(16'd5, 48'h0000_0005_1234, 2'd3, 6'd16, 1'b0, h, f, pa, msk, pm, n);
        chk(h == 1'b0, "R8 ctx 5 64K removed", 64'(h), 64'd0);
        lookup(16'd7, 48'h0000_C123_4568, 2'd1, 6'd16, 1'b0, h, f, pa, msk, pm, n);
        chk(h == 1'b1, "R8 ctx 7 kept", 64'(h), 64'd1);

        // invalidate all
        maint(2'd0, 1'b0, 16'd0, 48'h0);
        lookup(16'd7, 48'h0000_C123_4568, 2'd1, 6'd16, 1'b0, h, f, pa, msk, pm, n);
        chk(h == 1'b0, "R7 all removed", 64'(h), 64'd0);

        // fill masks unaligned bases
        fill(16'd2, 48'h0000_4025_5555, 2'd1, 2'd2, 48'h0000_8012_3456, 2'd3);
        lookup(16'd2, 48'h0000_4020_0010, 2'd1, 6'd16, 1'b0, h, f, pa, msk, pm, n);
        chk(pa == 48'h0000_8000_0010, "R6 bases aligned on fill", 64'(pa), 64'h8000_0010);
        maint(2'd0, 1'b0, 16'd0, 48'h0);

        // full cache flush on insert
        for (int k = 1; k <= N; k++)
            fill(16'd3, 48'(k * 'h1000), 2'd1, 2'd3, 48'(k * 'h10000), 2'd3);
        lookup(16'd3, 48'h0000_0000_4008, 2'd1, 6'd16, 1'b0, h, f, pa, msk, pm, n);
        chk(h == 1'b1 && pa == 48'h40008, "R6 last slot filled", 64'(pa), 64'h40008);
        lookup(16'd3, 48'h0000_0000_1008, 2'd1, 6'd16, 1'b0, h, f, pa, msk, pm, n);
        chk(h == 1'b1, "R6 first slot filled", 64'(h), 64'd1);
        fill(16'd3, 48'h0000_0000_9000, 2'd1, 2'd3, 48'h0000_0099_0000, 2'd3);
        lookup(16'd3, 48'h0000_0000_9008, 2'd1, 6'd16, 1'b0, h, f, pa, msk, pm, n);
        chk(h == 1'b1 && pa == 48'h99_0008, "R6 new entry after flush", 64'(pa), 64'h99_0008);
        lookup(16'd3, 48'h0000_0000_1008, 2'd1, 6'd16, 1'b0, h, f, pa, msk, pm, n);
        chk(h == 1'b0, "R6 old entries flushed", 64'(h), 64'd0);

        // maintenance during a probe holds it one cycle
        @(negedge clk);
        lk_req = 1; lk_asid = 16'd3; lk_addr = 48'h0000_0000_9008; lk_tg = 2'd1;
        lk_tsz = 6'd16; lk_write = 0;
        @(posedge clk);
        @(negedge clk);
        lk_req = 0;
        mt_valid = 1; mt_op = 2'd0; mt_any_asid = 0;
        @(posedge clk);
        @(negedge clk);
        mt_valid = 0;
        n = 1;
        while (!lk_done && n < 20) begin
            @(posedge clk); @(negedge clk);
            n++;
        end
        chk(lk_hit == 1'b0, "R10 probe sees invalidation", 64'(lk_hit), 64'd0);
        chk(n == 5, "R10 probe held one cycle", 64'(n), 64'd5);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule